// File: doc/BRIEF.md
# Full-Bridge Motor and Servo PWM Generator

This block produces pulse-width-modulated drive for one brushed DC motor and one steering servo from a single free-running period counter. The motor waveform is steered onto the enable and side-select inputs of two half-bridge power stages, which together form a full bridge. Each stage conducts only while its enable is high. With the enable high, a side-select of 1 drives that stage's output high and a side-select of 0 drives it low. The servo output is a plain PWM line that uses the same period.

A small write-only register port sets the period, a duty for each channel, and a control word that holds run enable, reverse direction and brake. Period and duty writes go to shadow copies. These copies become active only when the counter wraps, so a pulse is never cut short or stretched in the middle of a period. A period of zero stops the counter and puts every output into the safe-off state. A change of direction is never applied directly. The block first inserts one full period with both side-selects low, and only then switches.

Top module: `motor_pwm_bridge`

## Requirements
- R1: While reset is asserted and right after it is released, all five outputs are low and the active period is zero.
- R2: While the active period is zero, both bridge enables, both side-selects and the servo output are low.
- R3: With an active period P greater than 0, the counter runs 0 to P-1. A channel with active duty D below P is high for the first D counts of each period, so it is high for exactly D cycles in any P consecutive cycles.
- R4: A duty at or above the period keeps that channel high on every cycle. A duty of zero keeps it low on every cycle.
- R5: Register writes select by address: 0 period, 1 motor duty, 2 servo duty, 3 control. Period and duty writes become active only at the next counter wrap. An old period that is still running keeps the outputs unchanged on the cycle after the write.
- R6: When enabled and not braking, both enables are high. With control bit 1 (reverse) clear, side-select A carries the motor PWM and side-select B stays low. With the bit set, the roles are swapped.
- R7: Control bit 2 (brake), together with control bit 0 (enable), gives both enables high and both side-selects low. This takes effect two cycles after the write.
- R8: With control bit 0 (enable) clear, both enables and both side-selects are low. This takes effect two cycles after the write.
- R9: A change of the reverse bit during a running period causes at least one full period with both side-selects low before the new direction drives its bridge. The applied direction changes only at a wrap.
- R10: The servo output follows its own duty and does not depend on enable, brake or direction.
- R11: Both side-selects are never high on the same cycle, and a side-select is never high while its own enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 motor duty, 2 servo duty, 3 control |
| wr_data | input | CW | Write value; for control, bit0 enable, bit1 reverse, bit2 brake |
| bridge_a_inh | output | 1 | Enable of half bridge A |
| bridge_a_in | output | 1 | Side-select of half bridge A |
| bridge_b_inh | output | 1 | Enable of half bridge B |
| bridge_b_in | output | 1 | Side-select of half bridge B |
| servo_pwm | output | 1 | Servo PWM |

## Verification
A corrupted counter or active period shows up within one period as the wrong count of high cycles in a window of P cycles, on both the motor and the servo lines at once. If the shadow-to-active copy is lost or comes early, a new duty appears at the wrong wrap, and the mismatch is visible within one period of the write. A stuck or skipped dead-period flag appears at the next wrap after a reverse toggle, as a side-select that goes high too early or never switches over. A control decode error shows on the enables two cycles after the control write.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
    typedef enum logic [1:0] {
        REG_PERIOD   = 2'd0,
        REG_DUTY_MOT = 2'd1,
        REG_DUTY_SRV = 2'd2,
        REG_CTRL     = 2'd3
    } reg_addr_e;

    // bit2 brake, bit1 reverse, bit0 enable
    typedef struct packed {
        logic brake;
        logic reverse;
        logic enable;
    } ctrl_t;

    localparam int CH_MOTOR = 0;
    localparam int CH_SERVO = 1;
    localparam int NUM_CH   = 2;

    typedef struct packed {
        logic a_inh;
        logic a_in;
        logic b_inh;
        logic b_in;
        logic servo;
    } drive_t;
endpackage

// File: rtl/mpb_regs.sv
module mpb_regs
    import mpb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_addr,
    input  logic [CW-1:0]                wr_data,
    output logic [CW-1:0]                per_sh,
    output logic [NUM_CH-1:0][CW-1:0]    duty_sh,
    output ctrl_t                        ctrl
);
    typedef struct packed {
        logic [CW-1:0]             per;
        logic [NUM_CH-1:0][CW-1:0] duty;
        ctrl_t                     ctrl;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_PERIOD:   regs_d.per            = wr_data;
                REG_DUTY_MOT: regs_d.duty[CH_MOTOR] = wr_data;
                REG_DUTY_SRV: regs_d.duty[CH_SERVO] = wr_data;
                REG_CTRL:     regs_d.ctrl           = ctrl_t'(wr_data[2:0]);
                default:      regs_d                = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign per_sh  = regs_q.per;
    assign duty_sh = regs_q.duty;
    assign ctrl    = regs_q.ctrl;
endmodule

// File: rtl/mpb_timebase.sv
module mpb_timebase
    import mpb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CW-1:0]             per_sh,
    input  logic [NUM_CH-1:0][CW-1:0] duty_sh,
    input  logic                      dir_sh,
    output logic [CW-1:0]             cnt,
    output logic [CW-1:0]             per_act,
    output logic [NUM_CH-1:0][CW-1:0] duty_act,
    output logic                      dir_act,
    output logic                      dead
);
    typedef struct packed {
        logic [CW-1:0]             cnt;
        logic [CW-1:0]             per;
        logic [NUM_CH-1:0][CW-1:0] duty;
        logic                      dir;
        logic                      dead;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      run;
    logic      wrap;

    assign run  = (st_q.per != '0);
    assign wrap = !run || (st_q.cnt == st_q.per - 1'b1);

    always_comb begin
        st_d = st_q;
        if (wrap) begin
            st_d.cnt  = '0;
            st_d.per  = per_sh;
            st_d.duty = duty_sh;
            if (!run || st_q.dead) begin
                st_d.dir  = dir_sh;
                st_d.dead = 1'b0;
            end else if (dir_sh != st_q.dir) begin
                st_d.dead = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign per_act  = st_q.per;
    assign duty_act = st_q.duty;
    assign dir_act  = st_q.dir;
    assign dead     = st_q.dead;
endmodule

// File: rtl/mpb_cmp.sv
module mpb_cmp #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] per,
    input  logic [CW-1:0] duty,
    output logic          hi
);
    always_comb begin
        hi = (per != '0) && (cnt < duty);
    end
endmodule

// File: rtl/mpb_outmap.sv
module mpb_outmap
    import mpb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ctrl_t  ctrl,
    input  logic   run,
    input  logic   dir_act,
    input  logic   dead,
    input  logic   mot_hi,
    input  logic   srv_hi,
    output drive_t drv
);
    drive_t drv_d, drv_q;

    always_comb begin
        drv_d       = '0;
        drv_d.servo = srv_hi;
        if (ctrl.enable && run) begin
            drv_d.a_inh = 1'b1;
            drv_d.b_inh = 1'b1;
            if (!ctrl.brake && !dead) begin
                if (dir_act) drv_d.b_in = mot_hi;
                else         drv_d.a_in = mot_hi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign drv = drv_q;
endmodule

// File: rtl/motor_pwm_bridge.sv
module motor_pwm_bridge
    import mpb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          bridge_a_inh,
    output logic          bridge_a_in,
    output logic          bridge_b_inh,
    output logic          bridge_b_in,
    output logic          servo_pwm
);
    logic [CW-1:0]             per_sh;
    logic [NUM_CH-1:0][CW-1:0] duty_sh;
    ctrl_t                     ctrl_q;
    logic [CW-1:0]             cnt;
    logic [CW-1:0]             per_act;
    logic [NUM_CH-1:0][CW-1:0] duty_act;
    logic                      dir_act;
    logic                      dead;
    logic [NUM_CH-1:0]         ch_hi;
    drive_t                    drv;

    mpb_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .per_sh(per_sh), .duty_sh(duty_sh), .ctrl(ctrl_q)
    );

    mpb_timebase #(.CW(CW)) u_tbase (
        .clk(clk), .rst_n(rst_n), .per_sh(per_sh), .duty_sh(duty_sh),
        .dir_sh(ctrl_q.reverse), .cnt(cnt), .per_act(per_act),
        .duty_act(duty_act), .dir_act(dir_act), .dead(dead)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
        mpb_cmp #(.CW(CW)) u_cmp (
            .cnt(cnt), .per(per_act), .duty(duty_act[ch]), .hi(ch_hi[ch])
        );
    end

    mpb_outmap u_map (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .run(per_act != '0),
        .dir_act(dir_act), .dead(dead), .mot_hi(ch_hi[CH_MOTOR]),
        .srv_hi(ch_hi[CH_SERVO]), .drv(drv)
    );

    assign bridge_a_inh = drv.a_inh;
    assign bridge_a_in  = drv.a_in;
    assign bridge_b_inh = drv.b_inh;
    assign bridge_b_in  = drv.b_in;
    assign servo_pwm    = drv.servo;
endmodule

// File: rtl/mpb_checker.sv
module mpb_checker
    import mpb_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_inh,
    input logic          a_in,
    input logic          b_inh,
    input logic          b_in,
    input logic          servo,
    input ctrl_t         ctrl,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] per_act,
    input logic          dir_act,
    input logic          dead
);
    // R11: side-selects exclusive and gated by their own enable
    p_no_shoot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_in && b_in));
    p_a_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        a_in |-> a_inh);
    p_b_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        b_in |-> b_inh);
    // R3: counter stays inside the active period
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (per_act != '0) |-> (cnt < per_act));
    // R2: zero period gives safe-off
    p_zero_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(per_act == '0) |-> !(a_inh || b_inh || servo));
    // R8: disable gives coast
    p_coast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctrl.enable) |-> !(a_inh || b_inh));
    // R7: brake holds both low sides on
    p_brake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl.enable && ctrl.brake && per_act != '0)
        |-> (a_inh && b_inh && !a_in && !b_in));
    // R9: dead period keeps both side-selects low; direction moves only at a wrap
    p_dead_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dead) |-> (!a_in && !b_in));
    p_dir_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_act) |-> ($past(dead) || $past(per_act == '0)));
endmodule

bind motor_pwm_bridge mpb_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_inh(bridge_a_inh), .a_in(bridge_a_in),
    .b_inh(bridge_b_inh), .b_in(bridge_b_in), .servo(servo_pwm),
    .ctrl(ctrl_q), .cnt(cnt), .per_act(per_act),
    .dir_act(dir_act), .dead(dead)
);

// File: tb/tb_motor_pwm_bridge.sv
`timescale 1ns/1ps
module tb_motor_pwm_bridge;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          a_inh, a_in, b_inh, b_in, servo;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    motor_pwm_bridge #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bridge_a_inh(a_inh), .bridge_a_in(a_in),
        .bridge_b_inh(b_inh), .bridge_b_in(b_in), .servo_pwm(servo)
    );

    // reference model built from the requirements
    logic [CW-1:0] m_per_sh = '0, m_dm_sh = '0, m_ds_sh = '0;
    logic          m_en = 0, m_rev = 0, m_brk = 0;
    logic [CW-1:0] m_cnt = '0, m_per = '0, m_dm = '0, m_ds = '0;
    logic          m_dir = 0, m_dead = 0;
    logic [4:0]    m_out = '0;  // a_inh a_in b_inh b_in servo
    string         m_tag = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_per_sh = '0; m_dm_sh = '0; m_ds_sh = '0;
            m_en = 0; m_rev = 0; m_brk = 0;
            m_cnt = '0; m_per = '0; m_dm = '0; m_ds = '0;
            m_dir = 0; m_dead = 0; m_out = '0; m_tag = "R1";
        end else begin
            logic run, hm, hs, wrap;
            run = (m_per != 0);
            hm  = run && (m_cnt < m_dm);
            hs  = run && (m_cnt < m_ds);
            m_out = {4'b0000, hs};
            if (!run)            m_tag = "R2";
            else if (!m_en)      m_tag = "R8";
            else if (m_brk)      m_tag = "R7";
            else if (m_dead)     m_tag = "R9";
            else                 m_tag = "R6";
            if (m_en && run) begin
                m_out[4] = 1'b1; m_out[2] = 1'b1;
                if (!m_brk && !m_dead) begin
                    if (m_dir) m_out[1] = hm;
                    else       m_out[3] = hm;
                end
            end
            wrap = !run || (m_cnt == m_per - 1'b1);
            if (wrap) begin
                m_cnt = '0;
                if (!run || m_dead) begin m_dir = m_rev; m_dead = 0; end
                else if (m_rev != m_dir) m_dead = 1;
                m_per = m_per_sh; m_dm = m_dm_sh; m_ds = m_ds_sh;
            end else begin
                m_cnt = m_cnt + 1'b1;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_per_sh = wr_data;
                    2'd1: m_dm_sh  = wr_data;
                    2'd2: m_ds_sh  = wr_data;
                    default: begin
                        m_en = wr_data[0]; m_rev = wr_data[1]; m_brk = wr_data[2];
                    end
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            if (failures <= 30)
                $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // advance one cycle; compare against the model at the falling edge
    task automatic tick();
        @(negedge clk);
        chk({a_inh, a_in, b_inh, b_in, servo} == m_out, m_tag, "outputs",
            int'({a_inh, a_in, b_inh, b_in, servo}), int'(m_out));
        if (servo !== m_out[0])
            chk(0, "R10", "servo", int'(servo), int'(m_out[0]));
    endtask

    task automatic wr(input logic [1:0] addr, input int data);
        wr_en = 1'b1; wr_addr = addr; wr_data = CW'(data);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // counts over n cycles: [0]=a_in [1]=b_in [2]=servo [3]=a_inh [4]=b_inh
    task automatic count(input int n, output int c[5]);
        for (int k = 0; k < 5; k++) c[k] = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            c[0] += int'(a_in); c[1] += int'(b_in); c[2] += int'(servo);
            c[3] += int'(a_inh); c[4] += int'(b_inh);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c[5];
        int run_len, best;
        void'($urandom(32'd20240611));
        @(negedge clk);
        chk({a_inh, a_in, b_inh, b_in, servo} == 5'b0, "R1", "reset outputs",
            int'({a_inh, a_in, b_inh, b_in, servo}), 0);
        idle(2);
        rst_n = 1'b1;
        idle(3);
        chk({a_inh, a_in, b_inh, b_in, servo} == 5'b0, "R1", "after reset",
            int'({a_inh, a_in, b_inh, b_in, servo}), 0);

        // forward, period 10, motor duty 3, servo duty 5
        wr(2'd1, 3); wr(2'd2, 5); wr(2'd3, 1); wr(2'd0, 10);
        idle(25);
        count(10, c);
        chk(c[0] == 3, "R3", "motor high count", c[0], 3);
        chk(c[2] == 5, "R3", "servo high count", c[2], 5);
        chk(c[1] == 0, "R6", "b_in forward", c[1], 0);
        chk(c[3] == 10 && c[4] == 10, "R6", "enables forward", c[3] + c[4], 20);

        // saturation and zero duty
        wr(2'd1, 15); idle(25); count(10, c);
        chk(c[0] == 10, "R4", "duty above period", c[0], 10);
        wr(2'd1, 0); idle(25); count(10, c);
        chk(c[0] == 0, "R4", "duty zero", c[0], 0);
        wr(2'd1, 3); idle(25);

        // reverse: dead period, then bridge B
        wr(2'd3, 3);
        best = 0; run_len = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (!a_in && !b_in) run_len++; else run_len = 0;
            if (run_len > best) best = run_len;
        end
        chk(best >= 10, "R9", "longest both-low run", best, 10);
        idle(10); count(10, c);
        chk(c[1] == 3 && c[0] == 0, "R6", "reverse b_in count", c[1], 3);

        // brake
        wr(2'd3, 7); tick();
        count(10, c);
        chk(c[3] == 10 && c[4] == 10 && c[0] == 0 && c[1] == 0, "R7", "brake",
            c[0] + c[1], 0);

        // disable: coast, servo continues
        wr(2'd3, 0); tick();
        count(10, c);
        chk(c[3] == 0 && c[4] == 0 && c[0] == 0 && c[1] == 0, "R8", "coast",
            c[3] + c[4], 0);
        chk(c[2] == 5, "R10", "servo while disabled", c[2], 5);

        // shadow period: zero period waits for the wrap
        wr(2'd3, 1); idle(25);
        wr(2'd0, 0);
        chk(servo == 1'b1 || a_inh == 1'b1, "R5", "old period still active",
            int'(a_inh), 1);
        idle(20); count(10, c);
        chk(c[2] + c[3] + c[4] + c[0] + c[1] == 0, "R2", "zero period off",
            c[2] + c[3], 0);

        // constrained random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) begin
                logic [1:0] adr;
                int val;
                adr = 2'($urandom_range(0, 3));
                case (adr)
                    2'd0: val = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, 12));
                    2'd3: val = int'($urandom_range(0, 7));
                    default: val = int'($urandom_range(0, 14));
                endcase
                wr(adr, val);
            end else begin
                tick();
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule